// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It holds two direction predictors and a chooser that picks between them for each branch. The first predictor is a per-address table of 2-bit saturating counters indexed by program-counter bits. The second predictor keeps a single outcome history that all conditional branches share. It indexes its own table of 2-bit counters with that history XORed with program-counter bits. A third table of 2-bit counters, also indexed by address, learns which of the two has been right more often for that address. The final direction is taken from whichever predictor the chooser currently favours.

Lookup is combinational from `lk_pc`. It returns the final direction and both component directions. When the branch resolves, the fetch side sends back the resolved outcome and the two component directions it saw at lookup. That one update trains both component tables and moves the chooser if the components disagreed. It also shifts the outcome into the shared history. The global table index used on an update is formed from the history as it stands at that update. Repair of speculatively shifted history is not handled here.

Top module: `tourney_bp`

## Requirements
- R1: After reset the shared history is all zero. Every component counter is weakly not taken (01), and every chooser counter is 01, which favours the per-address predictor. So every lookup returns not taken on all three direction outputs.
- R2: A counter predicts taken when its upper bit is 1. Counters use the encoding 00 strongly not taken, 01 weakly not taken, 10 weakly taken and 11 strongly taken. A taken outcome increments a counter, a not-taken outcome decrements it, and it saturates at 00 and 11.
- R3: A counter at 11 still predicts taken after one not-taken update. It predicts not taken only after a second one.
- R4: The per-address and chooser tables are indexed by the program-counter bits just above bit 2. The global table is indexed by the history XORed with the program-counter bits just above bit 2. Bits 2 to 0 of the address never affect a lookup.
- R5: Each accepted update shifts the history left by one place, with the resolved outcome (1 = taken) entering at bit 0.
- R6: The final direction equals the global predictor's direction when the chooser counter's upper bit is 1. It equals the per-address predictor's direction when that bit is 0. When the two components agree, the final direction is their common value.
- R7: When the returned component directions differ, the chooser counter moves one step toward the global side (increment) if the global direction matched the outcome, and one step toward the per-address side (decrement) otherwise. When they agree, the chooser is left unchanged.
- R8: Chooser training uses the component directions supplied with the update, not the current table contents.
- R9: A cycle without `up_valid` changes no table and no history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | Branch address being looked up |
| lk_taken | output | 1 | Final predicted direction |
| lk_bim | output | 1 | Per-address component direction |
| lk_glb | output | 1 | Global component direction |
| up_valid | input | 1 | Update strobe for a resolved branch |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Resolved outcome, 1 = taken |
| up_bim | input | 1 | Per-address direction returned at lookup |
| up_glb | input | 1 | Global direction returned at lookup |

## Verification
The bench builds the predictor with a 16-bit address, an 8-entry per-address table, an 8-entry global table with 3 bits of history, and a 4-entry chooser. At this size every counter, every history value and every aliasing between addresses can be reached within a few thousand updates. A reference model written from the counter and index rules then checks all three outputs on every lookup. Directed runs cover saturation, low address bits, an alternating branch that forces the chooser over to the global side, idle cycles, and updates whose returned directions differ from the current tables.

// File: rtl/tourney_bp.sv
module tourney_bp #(
  parameter int PC_W  = 32,
  parameter int BIM_W = 10,
  parameter int GLB_W = 11,
  parameter int CHS_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_taken,
  output logic            lk_bim,
  output logic            lk_glb,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken,
  input  logic            up_bim,
  input  logic            up_glb
);
  localparam int BIM_N = 1 << BIM_W;
  localparam int GLB_N = 1 << GLB_W;
  localparam int CHS_N = 1 << CHS_W;

  logic [1:0] bim_tab [BIM_N];
  logic [1:0] glb_tab [GLB_N];
  logic [1:0] chs_tab [CHS_N];
  logic [GLB_W-1:0] ghist;

  function automatic logic [1:0] bump(input logic [1:0] c, input logic up);
    if (up) return (c == 2'b11) ? c : c + 2'b01;
    else    return (c == 2'b00) ? c : c - 2'b01;
  endfunction

  wire [BIM_W-1:0] lk_bi = lk_pc[3 +: BIM_W];
  wire [GLB_W-1:0] lk_gi = ghist ^ lk_pc[3 +: GLB_W];
  wire [CHS_W-1:0] lk_ci = lk_pc[3 +: CHS_W];
  wire [BIM_W-1:0] up_bi = up_pc[3 +: BIM_W];
  wire [GLB_W-1:0] up_gi = ghist ^ up_pc[3 +: GLB_W];
  wire [CHS_W-1:0] up_ci = up_pc[3 +: CHS_W];

  assign lk_bim   = bim_tab[lk_bi][1];
  assign lk_glb   = glb_tab[lk_gi][1];
  assign lk_taken = chs_tab[lk_ci][1] ? lk_glb : lk_bim;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ghist <= '0;
      for (int i = 0; i < BIM_N; i++) bim_tab[i] <= 2'b01;
      for (int i = 0; i < GLB_N; i++) glb_tab[i] <= 2'b01;
      for (int i = 0; i < CHS_N; i++) chs_tab[i] <= 2'b01;
    end else if (up_valid) begin
      bim_tab[up_bi] <= bump(bim_tab[up_bi], up_taken);
      glb_tab[up_gi] <= bump(glb_tab[up_gi], up_taken);
      if (up_bim != up_glb)
        chs_tab[up_ci] <= bump(chs_tab[up_ci], up_glb == up_taken);
      ghist <= {ghist[GLB_W-2:0], up_taken};
    end
  end
endmodule

module tourney_bp_chk #(
  parameter int GLB_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic [GLB_W-1:0] ghist,
  input logic             up_valid,
  input logic             up_taken,
  input logic             lk_taken,
  input logic             lk_bim,
  input logic             lk_glb
);
  AST_HIST_CLEAR: assert property (@(posedge clk) $rose(rst_n) |-> ghist == '0); // R1
  AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> ghist == {$past(ghist[GLB_W-2:0]), $past(up_taken)}); // R5
  AST_HIST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> $stable(ghist)); // R9
  AST_AGREE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_bim == lk_glb |-> lk_taken == lk_bim); // R6
  AST_OUT_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown({lk_taken, lk_bim, lk_glb})); // R2
endmodule

bind tourney_bp tourney_bp_chk #(.GLB_W(GLB_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ghist(ghist), .up_valid(up_valid),
  .up_taken(up_taken), .lk_taken(lk_taken), .lk_bim(lk_bim), .lk_glb(lk_glb)
);

// File: tb/tb_tourney_bp.sv
module tb_tourney_bp;
  localparam int PC_W = 16, BW = 3, GW = 3, CW = 2;

  logic clk = 0, rst_n = 0;
  logic [PC_W-1:0] lk_pc = '0, up_pc = '0;
  logic up_valid = 0, up_taken = 0, up_bim = 0, up_glb = 0;
  logic lk_taken, lk_bim, lk_glb;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tourney_bp #(.PC_W(PC_W), .BIM_W(BW), .GLB_W(GW), .CHS_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken), .lk_bim(lk_bim),
    .lk_glb(lk_glb), .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
    .up_bim(up_bim), .up_glb(up_glb));

  logic [1:0] mb [1<<BW];
  logic [1:0] mg [1<<GW];
  logic [1:0] mc [1<<CW];
  logic [GW-1:0] mh;

  function automatic logic [1:0] sat(input logic [1:0] c, input logic t);
    if (t) return (c == 3) ? 2'd3 : c + 2'd1;
    return (c == 0) ? 2'd0 : c - 2'd1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < (1<<BW); i++) mb[i] = 2'b01;
    for (int i = 0; i < (1<<GW); i++) mg[i] = 2'b01;
    for (int i = 0; i < (1<<CW); i++) mc[i] = 2'b01;
    mh = '0;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic look(input logic [PC_W-1:0] pc, input string req);
    logic eb, eg, et;
    eb = mb[pc[3 +: BW]][1];
    eg = mg[mh ^ pc[3 +: GW]][1];
    et = mc[pc[3 +: CW]][1] ? eg : eb;
    lk_pc = pc;
    #1;
    chk({req, " bim"}, lk_bim, eb);
    chk({req, " glb"}, lk_glb, eg);
    chk({req, " final"}, lk_taken, et);
  endtask

  // look up, then update with the given outcome; own=1 returns chosen directions (R8)
  task automatic step(input logic [PC_W-1:0] pc, input logic t, input logic v,
                      input logic own, input logic fb, input logic fg, input string req);
    logic rb, rg;
    @(negedge clk);
    look(pc, req);
    rb = own ? fb : lk_bim;
    rg = own ? fg : lk_glb;
    up_valid = v; up_pc = pc; up_taken = t; up_bim = rb; up_glb = rg;
    @(posedge clk);
    if (v) begin
      mb[pc[3 +: BW]] = sat(mb[pc[3 +: BW]], t);
      mg[mh ^ pc[3 +: GW]] = sat(mg[mh ^ pc[3 +: GW]], t);
      if (rb != rg) mc[pc[3 +: CW]] = sat(mc[pc[3 +: CW]], rg == t);
      mh = {mh[GW-2:0], t};
    end
    #1 up_valid = 0;
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: every address predicts not taken out of reset
    for (int p = 0; p < 128; p += 4) begin
      @(negedge clk); lk_pc = p[PC_W-1:0]; #1;
      chk("R1 final", lk_taken, 1'b0);
      chk("R1 bim", lk_bim, 1'b0);
      chk("R1 glb", lk_glb, 1'b0);
    end
    // R2/R3: saturation up and two-step retreat on one address
    for (int k = 0; k < 4; k++) step(16'h0008, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R2 climb");
    step(16'h0008, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R3 first down");
    @(negedge clk); lk_pc = 16'h0008; #1;
    chk("R3 still taken", lk_bim, 1'b1);
    step(16'h0008, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R3 second down");
    @(negedge clk); lk_pc = 16'h0008; #1;
    chk("R3 flipped", lk_bim, 1'b0);
    // R4: low three address bits ignored
    for (int lo = 0; lo < 8; lo++) look(16'h0008 | 16'(lo), "R4 low bits");
    // R9: idle cycles change nothing
    for (int k = 0; k < 6; k++) step(16'h0010, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R9 idle");
    look(16'h0010, "R9 after idle");
    // R6/R7: alternating branch drives chooser to the global side
    for (int k = 0; k < 40; k++) step(16'h0020, k[0], 1'b1, 1'b0, 1'b0, 1'b0, "R7 alternate");
    @(negedge clk); lk_pc = 16'h0020; #1;
    chk("R6 global selected", lk_taken, 1'b0);
    chk("R6 follows global", lk_taken, lk_glb);
    // R8: returned directions decide chooser training
    for (int k = 0; k < 8; k++) step(16'h0028, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R8 push global");
    for (int k = 0; k < 8; k++) step(16'h0028, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R8 agree hold");
    // R5 and general sweep against the model
    for (int k = 0; k < 3000; k++) begin
      logic [PC_W-1:0] pc;
      logic [3:0] r;
      pc = 16'($urandom % 256);
      r = 4'($urandom);
      step(pc, r[0] ^ (pc[4] & r[1]), r[3:2] != 2'b00, r[3:1] == 3'b111,
           r[1], r[2], "R5 sweep");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule